// File: doc/BRIEF.md
# Two-Point Thermal Throttle Sequencer

This controller moves a processor between two operating points. Each point pairs a clock-ratio code with a voltage-ID (VID) code. The nominal point is where the processor runs normally. The reduced point trades speed for lower power. An over-temperature flag, qualified by an enable, selects which point is wanted. The sequencer then orders the change so that the supply voltage is never too low for the clock ratio in use.

When the processor throttles, the ratio drops first, inside a fixed blackout window. Bus traffic is stalled for that window. Edge interrupts that arrive during it are held and then released all together. After the window, the VID code walks one entry at a time toward the reduced code, and each code is held for a dwell count so the regulator can settle.

Recovery waits for a hysteresis timer to run out. The VID then walks back to nominal, and only after that does the ratio return, inside a second blackout window. A renewed over-temperature during the walk back reverses the walk without touching the ratio.

Top module: `throt_seq`

## Requirements
- R1: After reset the outputs are at the nominal point: `ratio_out` = `ratio_nom`, `vid_out` = `vid_nom`, `bus_block` = 0 and `irq_pend` = 0.
- R2: When `en` and `hot` are both high at the nominal point, the next state is a blackout with `ratio_out` = `ratio_low`. `vid_out` stays at `vid_nom` for the whole blackout, and the VID walk starts only after the blackout.
- R3: Each blackout (throttle or recovery) keeps `bus_block` high for exactly BLACKOUT_CYC consecutive cycles, and the ratio output changes only in blackout cycles.
- R4: A rising edge on bit i of `irq_in` outside a blackout sets bit i of `irq_pend` for one cycle, in the following cycle. Edges that arrive during a blackout keep `irq_pend` at zero. Their OR appears in `irq_pend` for one cycle, in the second cycle after `bus_block` falls.
- R5: The VID moves by exactly one code per step and holds each code for DWELL_CYC cycles. A larger code means a lower voltage, so throttling increments the code and recovery decrements it.
- R6: `bus_block` stays low while the VID is walking.
- R7: Recovery starts only after the effective over-temperature (`en` AND `hot`) has been low for HYST_CYC consecutive cycles at the reduced point. Any reassertion restarts the count.
- R8: On recovery, the VID reaches `vid_nom` while `ratio_out` is still `ratio_low`. Only then does the ratio return to `ratio_nom`, inside a blackout.
- R9: While `en` is low at the nominal point, `hot` has no effect on any output.
- R10: Dropping `en` at the reduced point acts the same as a cooled processor: the hysteresis and recovery sequence follow.
- R11: If over-temperature reasserts during the recovery walk, the VID turns back toward `vid_low` from its current code. There is no blackout and no ratio change.
- R12: When `vid_low` equals `vid_nom`, no VID steps occur, but both blackouts still take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Throttling enable |
| hot | input | 1 | Temperature above limit |
| ratio_nom | input | RATIO_W | Clock-ratio code of the nominal point |
| vid_nom | input | VID_W | VID code of the nominal point |
| ratio_low | input | RATIO_W | Clock-ratio code of the reduced point |
| vid_low | input | VID_W | VID code of the reduced point (numerically at least `vid_nom`) |
| irq_in | input | IRQ_N | Raw edge-interrupt request lines |
| ratio_out | output | RATIO_W | Clock-ratio code in use |
| vid_out | output | VID_W | VID code sent to the regulator |
| bus_block | output | 1 | Bus traffic stalled (blackout window) |
| irq_pend | output | IRQ_N | Interrupt edges presented to the core |

## Verification
The hardest case to reach is a change of mind in the middle of recovery. Over-temperature must come back after the hysteresis timer has expired but before the VID has reached nominal. A second hard case is a reassertion one cycle before the hysteresis timer would expire. The bench counts the dwell and hysteresis cycles from a small configuration. It toggles `hot` at exactly the cycle where the first recovery step has just been issued, and at the cycle just before expiry. Each case is then checked against the arithmetic progression of codes the requirements predict. The sweep also covers equal and unequal VID pairs, interrupt edges inside the blackout, and recovery started by dropping `en`.

// File: rtl/throt_pkg.sv
package throt_pkg;
  typedef enum logic [2:0] {
    S_NORM  = 3'd0,
    S_FDOWN = 3'd1,
    S_VDOWN = 3'd2,
    S_LOW   = 3'd3,
    S_VUP   = 3'd4,
    S_FUP   = 3'd5
  } tstate_e;
endpackage

// File: rtl/cyc_timer.sv
module cyc_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!done)  cnt <= cnt + 1'b1;
  end

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/vid_stepper.sv
module vid_stepper #(
  parameter int unsigned VID_W = 6,
  parameter int unsigned DWELL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VID_W-1:0] load_val,
  input  logic             run,
  input  logic [VID_W-1:0] target,
  output logic [VID_W-1:0] vid,
  output logic             at_tgt,
  output logic             step_ev
);
  localparam int unsigned DW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [DW-1:0] DLAST = DW'(DWELL - 1);

  logic [DW-1:0] dcnt;

  function automatic logic [VID_W-1:0] toward(input logic [VID_W-1:0] cur,
                                              input logic [VID_W-1:0] tgt);
    if (cur < tgt)      return cur + 1'b1;
    else if (cur > tgt) return cur - 1'b1;
    else                return cur;
  endfunction

  assign at_tgt  = (vid == target);
  assign step_ev = run && !at_tgt && (dcnt == DLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid  <= '0;
      dcnt <= '0;
    end else if (load) begin
      vid  <= load_val;
      dcnt <= '0;
    end else if (run && !at_tgt) begin
      if (step_ev) begin
        vid  <= toward(vid, target);
        dcnt <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end else begin
      dcnt <= '0;
    end
  end

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (vid == $past(vid) || vid == $past(vid) + 1'b1 || vid == $past(vid) - 1'b1));
endmodule

// File: rtl/irq_hold.sv
module irq_hold #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blk,
  input  logic [N-1:0] req,
  output logic [N-1:0] pend
);
  logic [N-1:0] req_q;
  logic [N-1:0] held;
  logic [N-1:0] rise;

  assign rise = req & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      held  <= '0;
      pend  <= '0;
    end else begin
      req_q <= req;
      if (blk) begin
        held <= held | rise;
        pend <= '0;
      end else begin
        held <= '0;
        pend <= held | rise;
      end
    end
  end

  a_r4_quiet_in_blackout: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> (pend == '0));
endmodule

// File: rtl/throt_seq.sv
module throt_seq
  import throt_pkg::*;
#(
  parameter int unsigned RATIO_W      = 6,
  parameter int unsigned VID_W        = 6,
  parameter int unsigned IRQ_N        = 4,
  parameter int unsigned BLACKOUT_CYC = 625,
  parameter int unsigned DWELL_CYC    = 64,
  parameter int unsigned HYST_CYC     = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               hot,
  input  logic [RATIO_W-1:0] ratio_nom,
  input  logic [VID_W-1:0]   vid_nom,
  input  logic [RATIO_W-1:0] ratio_low,
  input  logic [VID_W-1:0]   vid_low,
  input  logic [IRQ_N-1:0]   irq_in,
  output logic [RATIO_W-1:0] ratio_out,
  output logic [VID_W-1:0]   vid_out,
  output logic               bus_block,
  output logic [IRQ_N-1:0]   irq_pend
);
  tstate_e state, state_nx;

  logic hot_eff;
  logic bl_run, bl_done;
  logic hy_run, hy_done;
  logic st_load, st_run, at_tgt, vid_step;
  logic [VID_W-1:0] vid_tgt, vid_r;

  assign hot_eff = en & hot;
  assign bl_run  = (state == S_FDOWN) || (state == S_FUP);
  assign hy_run  = (state == S_LOW) && !hot_eff;
  assign st_load = (state == S_NORM) || (state == S_FDOWN);
  assign st_run  = (state == S_VDOWN) || (state == S_VUP);
  assign vid_tgt = (state == S_VUP) ? vid_nom : vid_low;

  cyc_timer #(.LEN(BLACKOUT_CYC)) u_blk (
    .clk(clk), .rst_n(rst_n), .run(bl_run), .done(bl_done));

  cyc_timer #(.LEN(HYST_CYC)) u_hyst (
    .clk(clk), .rst_n(rst_n), .run(hy_run), .done(hy_done));

  vid_stepper #(.VID_W(VID_W), .DWELL(DWELL_CYC)) u_vid (
    .clk(clk), .rst_n(rst_n), .load(st_load), .load_val(vid_nom),
    .run(st_run), .target(vid_tgt), .vid(vid_r), .at_tgt(at_tgt),
    .step_ev(vid_step));

  irq_hold #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .blk(bus_block), .req(irq_in), .pend(irq_pend));

  always_comb begin
    state_nx = state;
    unique case (state)
      S_NORM:  if (hot_eff) state_nx = S_FDOWN;
      S_FDOWN: if (bl_done) state_nx = S_VDOWN;
      S_VDOWN: if (at_tgt)  state_nx = S_LOW;
      S_LOW:   if (hy_done) state_nx = S_VUP;
      S_VUP: begin
        if (hot_eff)     state_nx = S_VDOWN;
        else if (at_tgt) state_nx = S_FUP;
      end
      S_FUP:   if (bl_done) state_nx = S_NORM;
      default: state_nx = S_NORM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_NORM;
    else        state <= state_nx;
  end

  assign bus_block = bl_run;
  assign ratio_out = ((state == S_NORM) || (state == S_FUP)) ? ratio_nom : ratio_low;
  assign vid_out   = st_load ? vid_nom : vid_r;

  a_r2_no_step_in_blackout: assert property (@(posedge clk) disable iff (!rst_n)
    bus_block |-> !vid_step);

  a_r3_ratio_moves_in_blackout: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_out != $past(ratio_out)) |-> bus_block);

  a_r9_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && state == S_NORM) |=> (state == S_NORM));

  a_r11_reverse_no_block: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VUP && hot_eff) |=> !bus_block);

  a_r6_walk_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
    vid_step |-> !bus_block);
endmodule

// File: tb/sim_throt_seq.sv
module sim_throt_seq;
  localparam int RW = 6, VW = 6, NI = 4;
  localparam int BL = 6, DW = 3, HY = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, hot = 1'b0;
  logic [RW-1:0] ratio_nom = '0, ratio_low = '0;
  logic [VW-1:0] vid_nom = '0, vid_low = '0;
  logic [NI-1:0] irq_in = '0;
  logic [RW-1:0] ratio_out;
  logic [VW-1:0] vid_out;
  logic bus_block;
  logic [NI-1:0] irq_pend;

  int total = 0, bad = 0;
  int vn, vl, rn, rl, dl;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  throt_seq #(.RATIO_W(RW), .VID_W(VW), .IRQ_N(NI),
              .BLACKOUT_CYC(BL), .DWELL_CYC(DW), .HYST_CYC(HY)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .hot(hot),
    .ratio_nom(ratio_nom), .vid_nom(vid_nom), .ratio_low(ratio_low),
    .vid_low(vid_low), .irq_in(irq_in), .ratio_out(ratio_out),
    .vid_out(vid_out), .bus_block(bus_block), .irq_pend(irq_pend));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2 R3 R4 R5 R6: throttle entry with interrupt edges inside the blackout
  task automatic do_down();
    int n, cnt, vbad, wait_n;
    en = 1'b1; hot = 1'b1;
    wait_n = 0;
    tick();
    while (!bus_block && wait_n < 6) begin tick(); wait_n++; end
    chk("R2 ratio at blackout", int'(ratio_out), rl);
    cnt = 1; vbad = 0;
    forever begin
      if (int'(vid_out) != vn || irq_pend != '0) vbad++;
      case (cnt)
        1: irq_in = 4'b0001;
        3: irq_in = 4'b0100;
        default: irq_in = '0;
      endcase
      tick();
      if (!bus_block) break;
      cnt++;
    end
    irq_in = '0;
    chk("R3 throttle blackout length", cnt, BL);
    chk("R2 vid held, irq quiet in blackout", vbad, 0);
    n = dl * DW + 2;
    for (int j = 0; j < n; j++) begin
      int e;
      e = vn + ((j / DW < dl) ? j / DW : dl);
      chk("R5 vid walk down", int'(vid_out), e);
      chk("R6 no block while walking", int'(bus_block), 0);
      if (j == 0) chk("R4 held irq not yet out", int'(irq_pend), 0);
      if (j == 1) chk("R4 held irq released", int'(irq_pend), 5);
      if (j == 2) chk("R4 held irq one cycle", int'(irq_pend), 0);
      tick();
    end
  endtask

  // R7 R10: hysteresis with a restart one cycle before expiry
  task automatic do_cool(input bit use_en);
    int vbad;
    vbad = 0;
    if (use_en) en = 1'b0; else hot = 1'b0;
    for (int k = 1; k < HY; k++) begin
      tick();
      if (int'(vid_out) != vl || int'(ratio_out) != rl || bus_block) vbad++;
    end
    if (use_en) en = 1'b1; else hot = 1'b1;
    tick();
    if (use_en) en = 1'b0; else hot = 1'b0;
    for (int k = 1; k <= HY; k++) begin
      tick();
      if (int'(vid_out) != vl || int'(ratio_out) != rl || bus_block) vbad++;
    end
    chk(use_en ? "R10 en drop waits hysteresis" : "R7 hysteresis restart", vbad, 0);
  endtask

  // R8 R5 R3: recovery walk then ratio blackout
  task automatic do_return();
    int prev, vbad, cnt, guard;
    prev = vl; vbad = 0; guard = 0;
    while (!bus_block && guard < 200) begin
      if (int'(ratio_out) != rl) vbad++;
      if (int'(vid_out) != prev) begin
        if (int'(vid_out) != prev - 1) vbad++;
        prev = int'(vid_out);
      end
      tick();
      guard++;
    end
    chk("R5 R8 recovery walk steps", vbad, 0);
    chk("R8 vid nominal before ratio", int'(vid_out), vn);
    chk("R8 ratio back in blackout", int'(ratio_out), rn);
    cnt = 0;
    while (bus_block && cnt < 50) begin tick(); cnt++; end
    chk("R3 recovery blackout length", cnt, BL);
    chk("R8 final ratio", int'(ratio_out), rn);
    chk("R8 final vid", int'(vid_out), vn);
  endtask

  initial begin
    for (int p = 0; p < 6; p++) begin
      int vbad;
      rst_n = 1'b0; en = 1'b0; hot = 1'b0; irq_in = '0;
      vn = (p < 3) ? 10 : 40;
      dl = (p % 3 == 2) ? 3 : (p % 3);
      vl = vn + dl;
      rn = 24 + p; rl = 12 + p;
      ratio_nom = RW'(rn); ratio_low = RW'(rl);
      vid_nom = VW'(vn); vid_low = VW'(vl);
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 reset ratio", int'(ratio_out), rn);
      chk("R1 reset vid", int'(vid_out), vn);
      chk("R1 reset block", int'(bus_block), 0);
      chk("R1 reset irq", int'(irq_pend), 0);
      irq_in = 4'b0010;
      tick();
      chk("R4 direct edge", int'(irq_pend), 2);
      irq_in = '0;
      tick();
      chk("R4 direct one cycle", int'(irq_pend), 0);
      hot = 1'b1; vbad = 0;
      for (int k = 0; k < 20; k++) begin
        tick();
        if (bus_block || int'(ratio_out) != rn || int'(vid_out) != vn) vbad++;
      end
      chk("R9 disabled ignores hot", vbad, 0);
      do_down();
      chk(dl == 0 ? "R12 equal codes reach low" : "R5 reached low", int'(vid_out), vl);
      if (p == 5) begin
        hot = 1'b0;
        for (int k = 0; k < HY + DW; k++) tick();
        chk("R5 first recovery step", int'(vid_out), vl - 1);
        hot = 1'b1; vbad = 0;
        for (int k = 0; k < 4 * DW + 4; k++) begin
          tick();
          if (bus_block || int'(ratio_out) != rl) vbad++;
        end
        chk("R11 reversal no blackout", vbad, 0);
        chk("R11 reversal back to low", int'(vid_out), vl);
      end
      do_cool(p == 4);
      do_return();
      if (p == 4) begin
        hot = 1'b1; vbad = 0;
        for (int k = 0; k < 20; k++) begin
          tick();
          if (bus_block || int'(ratio_out) != rn) vbad++;
        end
        chk("R9 disabled after recovery", vbad, 0);
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule